// File: doc/BRIEF.md
# Two-Level 32-Bit Page Walker

This block translates a 32-bit virtual address into a physical address by walking a two-level table held in memory. The first level is a directory of 1024 32-bit entries, indexed by the top ten virtual bits. The second level is a table of 1024 entries, indexed by the next ten bits. A directory entry may instead describe a 4 MiB page, which carries eight extra physical address bits. A result can therefore reach 40 bits.

A request is started with a one-cycle `start` pulse that carries the virtual address, the root base register and the large-page enable. The walker then issues reads and at most one write on a simple request/acknowledge memory port. It finishes with a one-cycle `done` pulse. The result stays on the outputs until the next walk completes. The result is one of two things:

- A translation, with the page size, the ANDed user and write attributes, and the leaf entry and its address.
- A fault, either not-present or reserved.

Permission checks, the dirty-bit update and translation caching belong to the logic downstream.

Top module: `pw32_walker`

## Requirements
- R1: The directory entry is read from address {root_base[31:12], vaddr[31:22], 2'b00}. Bits [11:0] of `root_base` have no effect.
- R2: The table entry is read from address {directory_entry[31:12], vaddr[21:12], 2'b00}.
- R3: Bit 0 is the present bit. If it is clear in the directory entry or in the table entry, the walk ends with `fault`=1 and `fault_kind`=1 (not present), and no further memory access is made.
- R4: A directory entry maps a 4 MiB page only when `large_en` is 1 and entry bit 7 is 1. With `large_en`=0, bit 7 is ignored and the walk goes on to the table.
- R5: For a 4 MiB page, `paddr` = {entry[20:13], entry[31:22], vaddr[21:0]} and `page_large`=1. Exactly one memory access is made, and no write-back happens.
- R6: If entry bit 21 of a 4 MiB page entry is set, the walk ends with `fault`=1 and `fault_kind`=2 (reserved).
- R7: Bit 5 is the accessed bit. When the walk descends to a table and the directory's accessed bit is clear, the walker writes the directory entry with bit 5 set back to the directory address before it reads the table. In every other case, no write is issued.
- R8: For a 4 KiB page, `paddr` = {8'h00, table_entry[31:12], vaddr[11:0]} and `page_large`=0. No other entry bits are checked, so bits set in other positions raise no fault.
- R9: `user_ok` is bit 2 of the directory AND bit 2 of the table, and `write_ok` is bit 1 of both ANDed together. For a 4 MiB page, both are taken from the directory entry alone.
- R10: `leaf_entry` and `leaf_addr` give the last entry read and its address. On a fault, this is the entry that caused the fault.
- R11: `done` is a single-cycle pulse, and its results hold until the next walk ends. A `start` raised while a walk is in progress has no effect. `mem_req` and `mem_addr` hold steady until `mem_ack`.
- R12: After reset, `mem_req`, `done` and `fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Directory base register |
| large_en | input | 1 | Allow 4 MiB pages |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Write data (entry with accessed bit set) |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Walk finished (one cycle) |
| fault | output | 1 | Walk ended in a fault |
| fault_kind | output | 2 | 0 none, 1 not present, 2 reserved |
| paddr | output | 40 | Translated physical address |
| page_large | output | 1 | Result is a 4 MiB page |
| user_ok | output | 1 | Combined user attribute |
| write_ok | output | 1 | Combined write attribute |
| leaf_entry | output | 32 | Last entry read |
| leaf_addr | output | 32 | Address of that entry |

## Verification
The hardest case to reach from the ports is a `start` that arrives while a walk is still waiting on memory. That request has to leave no trace: no changed address, no extra access and no second `done`. The bench raises `start` with a different address in the middle of a three-access walk. It then checks that the access log and the result belong to the first request only, and that the port stays quiet afterwards. Write-back is checked separately, with the accessed bit clear and then set, in both page sizes. This confirms that exactly one write appears, and only on the path that descends to a table.

// File: rtl/pw32_pkg.sv
package pw32_pkg;
   localparam int unsigned ENT_W  = 32;
   localparam int unsigned IDX_W  = 10;
   localparam int unsigned OFS_W  = 12;
   localparam int unsigned BIG_W  = 22;
   localparam int unsigned F_PRES = 0;
   localparam int unsigned F_WR   = 1;
   localparam int unsigned F_USR  = 2;
   localparam int unsigned F_ACC  = 5;
   localparam int unsigned F_BIG  = 7;
   localparam int unsigned F_HOLE = 21;
   localparam int unsigned HI_LSB = 13;
   localparam int unsigned HI_MAX = 8;

   typedef enum logic [1:0] {
      WF_NONE   = 2'd0,
      WF_ABSENT = 2'd1,
      WF_RSVD   = 2'd2
   } walk_fault_e;

   typedef enum logic [1:0] {
      WS_IDLE   = 2'd0,
      WS_DIR_RD = 2'd1,
      WS_DIR_WB = 2'd2,
      WS_TBL_RD = 2'd3
   } walk_state_e;

   typedef struct packed {
      logic present;
      logic accessed;
      logic big;
      logic hole;
      logic usr;
      logic wr;
   } ent_info_t;
endpackage

// File: rtl/pw32_addr_gen.sv
module pw32_addr_gen import pw32_pkg::*; #(
   parameter int unsigned VA_W = 32
) (
   input  logic [VA_W-1:0]  va,
   input  logic [VA_W-1:0]  base,
   input  logic [ENT_W-1:0] dir_ent,
   output logic [VA_W-1:0]  dir_addr,
   output logic [VA_W-1:0]  tbl_addr
);
   localparam int unsigned SH     = $clog2(ENT_W / 8);
   localparam int unsigned FRM_W  = VA_W - OFS_W;
   localparam int unsigned T_TOP  = VA_W - IDX_W - 1;

   generate
      if (IDX_W + SH != OFS_W) begin : g_bad_geom
         $error("pw32_addr_gen: index plus entry shift must fill the page offset");
      end
   endgenerate

   assign dir_addr = {base[VA_W-1:OFS_W], va[VA_W-1 -: IDX_W], {SH{1'b0}}};
   assign tbl_addr = {dir_ent[OFS_W +: FRM_W], va[T_TOP -: IDX_W], {SH{1'b0}}};
endmodule

// File: rtl/pw32_entry_dec.sv
module pw32_entry_dec import pw32_pkg::*; (
   input  logic [ENT_W-1:0] ent,
   input  logic             big_ok,
   output ent_info_t        info
);
   always_comb begin
      info.present  = ent[F_PRES];
      info.accessed = ent[F_ACC];
      info.big      = big_ok & ent[F_BIG];
      info.hole     = ent[F_HOLE];
      info.usr      = ent[F_USR];
      info.wr       = ent[F_WR];
   end
endmodule

// File: rtl/pw32_paddr.sv
module pw32_paddr import pw32_pkg::*; #(
   parameter int unsigned PA_W = 40,
   parameter int unsigned VA_W = 32
) (
   input  logic [VA_W-1:0]  va,
   input  logic [ENT_W-1:0] ent,
   input  logic             big,
   output logic [PA_W-1:0]  paddr
);
   localparam int unsigned HI_USE = PA_W - VA_W;
   localparam int unsigned BFRM_W = VA_W - BIG_W;
   localparam int unsigned SFRM_W = VA_W - OFS_W;

   logic [PA_W-1:0] pa_big;
   logic [PA_W-1:0] pa_small;

   generate
      if (HI_USE > 0) begin : g_ext
         assign pa_big = {ent[HI_LSB +: HI_USE], ent[BIG_W +: BFRM_W], va[BIG_W-1:0]};
      end else begin : g_flat
         assign pa_big = PA_W'({ent[BIG_W +: BFRM_W], va[BIG_W-1:0]});
      end
   endgenerate

   assign pa_small = PA_W'({ent[OFS_W +: SFRM_W], va[OFS_W-1:0]});
   assign paddr    = big ? pa_big : pa_small;
endmodule

// File: rtl/pw32_walker.sv
module pw32_walker import pw32_pkg::*; #(
   parameter int unsigned PA_W = 40,
   parameter int unsigned VA_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [VA_W-1:0]  vaddr,
   input  logic [VA_W-1:0]  root_base,
   input  logic             large_en,
   output logic             mem_req,
   output logic             mem_we,
   output logic [VA_W-1:0]  mem_addr,
   output logic [ENT_W-1:0] mem_wdata,
   input  logic             mem_ack,
   input  logic [ENT_W-1:0] mem_rdata,
   output logic             done,
   output logic             fault,
   output logic [1:0]       fault_kind,
   output logic [PA_W-1:0]  paddr,
   output logic             page_large,
   output logic             user_ok,
   output logic             write_ok,
   output logic [ENT_W-1:0] leaf_entry,
   output logic [VA_W-1:0]  leaf_addr
);
   generate
      if (VA_W != ENT_W) begin : g_bad_va
         $error("pw32_walker: virtual width must equal entry width");
      end
      if (PA_W < VA_W || PA_W > VA_W + HI_MAX) begin : g_bad_pa
         $error("pw32_walker: physical width out of range");
      end
   endgenerate

   walk_state_e      state_q, state_d;
   logic [VA_W-1:0]  va_q, base_q;
   logic             big_en_q;
   logic [ENT_W-1:0] dir_q;

   logic [VA_W-1:0]  dir_addr, tbl_addr;
   ent_info_t        info;
   logic [PA_W-1:0]  pa_w;

   logic             fin;
   walk_fault_e      fin_kind;
   logic             fin_large;
   logic             fin_usr, fin_wr;
   logic [VA_W-1:0]  fin_addr;

   pw32_addr_gen #(.VA_W(VA_W)) u_addr (
      .va       (va_q),
      .base     (base_q),
      .dir_ent  (dir_q),
      .dir_addr (dir_addr),
      .tbl_addr (tbl_addr)
   );

   pw32_entry_dec u_dec (
      .ent    (mem_rdata),
      .big_ok (big_en_q && (state_q == WS_DIR_RD)),
      .info   (info)
   );

   pw32_paddr #(.PA_W(PA_W), .VA_W(VA_W)) u_pa (
      .va    (va_q),
      .ent   (mem_rdata),
      .big   (info.big),
      .paddr (pa_w)
   );

   assign mem_req   = (state_q != WS_IDLE);
   assign mem_we    = (state_q == WS_DIR_WB);
   assign mem_addr  = (state_q == WS_TBL_RD) ? tbl_addr : dir_addr;
   assign mem_wdata = dir_q | (ENT_W'(1) << F_ACC);

   always_comb begin
      state_d   = state_q;
      fin       = 1'b0;
      fin_kind  = WF_NONE;
      fin_large = 1'b0;
      fin_usr   = 1'b0;
      fin_wr    = 1'b0;
      fin_addr  = dir_addr;
      unique case (state_q)
         WS_IDLE: begin
            if (start) state_d = WS_DIR_RD;
         end
         WS_DIR_RD: begin
            if (mem_ack) begin
               if (!info.present) begin
                  fin      = 1'b1;
                  fin_kind = WF_ABSENT;
               end else if (info.big) begin
                  fin       = 1'b1;
                  fin_large = 1'b1;
                  fin_kind  = info.hole ? WF_RSVD : WF_NONE;
                  fin_usr   = info.usr;
                  fin_wr    = info.wr;
               end else if (!info.accessed) begin
                  state_d = WS_DIR_WB;
               end else begin
                  state_d = WS_TBL_RD;
               end
            end
         end
         WS_DIR_WB: begin
            if (mem_ack) state_d = WS_TBL_RD;
         end
         WS_TBL_RD: begin
            fin_addr = tbl_addr;
            if (mem_ack) begin
               fin      = 1'b1;
               fin_kind = info.present ? WF_NONE : WF_ABSENT;
               fin_usr  = dir_q[F_USR] & info.usr;
               fin_wr   = dir_q[F_WR] & info.wr;
            end
         end
         default: state_d = WS_IDLE;
      endcase
      if (fin) state_d = WS_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= WS_IDLE;
         va_q       <= '0;
         base_q     <= '0;
         big_en_q   <= 1'b0;
         dir_q      <= '0;
         done       <= 1'b0;
         fault      <= 1'b0;
         fault_kind <= WF_NONE;
         paddr      <= '0;
         page_large <= 1'b0;
         user_ok    <= 1'b0;
         write_ok   <= 1'b0;
         leaf_entry <= '0;
         leaf_addr  <= '0;
      end else begin
         state_q <= state_d;
         done    <= fin;
         if (state_q == WS_IDLE && start) begin
            va_q     <= vaddr;
            base_q   <= root_base;
            big_en_q <= large_en;
         end
         if (state_q == WS_DIR_RD && mem_ack) begin
            dir_q <= mem_rdata;
         end
         if (fin) begin
            fault      <= (fin_kind != WF_NONE);
            fault_kind <= fin_kind;
            paddr      <= (fin_kind == WF_NONE) ? pa_w : '0;
            page_large <= (fin_kind == WF_NONE) && fin_large;
            user_ok    <= (fin_kind == WF_NONE) && fin_usr;
            write_ok   <= (fin_kind == WF_NONE) && fin_wr;
            leaf_entry <= mem_rdata;
            leaf_addr  <= fin_addr;
         end
      end
   end
endmodule

// File: rtl/pw32_walker_chk.sv
module pw32_walker_chk import pw32_pkg::*; #(
   parameter int unsigned PA_W = 40,
   parameter int unsigned VA_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mem_req,
   input logic             mem_we,
   input logic [VA_W-1:0]  mem_addr,
   input logic [ENT_W-1:0] mem_wdata,
   input logic             mem_ack,
   input logic             done,
   input logic             fault,
   input logic [1:0]       fault_kind,
   input logic [PA_W-1:0]  paddr,
   input logic             page_large,
   input logic [ENT_W-1:0] leaf_entry
);
   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   a_r7_wb_sets_acc: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[F_ACC]);

   a_r7_wb_then_read: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

   a_r3_absent_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault_kind == 2'd1) |-> (fault && !leaf_entry[F_PRES]));

   a_r6_no_hole_in_big: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault && page_large) |-> !leaf_entry[F_HOLE]);

   a_r5_big_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault && page_large) |-> (paddr[VA_W-1:BIG_W] == leaf_entry[VA_W-1:BIG_W]));

   a_r8_small_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault && !page_large) |->
         (paddr[VA_W-1:OFS_W] == leaf_entry[VA_W-1:OFS_W] && (paddr >> VA_W) == '0));

   a_r12_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!mem_req && !done));
endmodule

bind pw32_walker pw32_walker_chk #(.PA_W(PA_W), .VA_W(VA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .mem_ack    (mem_ack),
   .done       (done),
   .fault      (fault),
   .fault_kind (fault_kind),
   .paddr      (paddr),
   .page_large (page_large),
   .leaf_entry (leaf_entry)
);

// File: tb/pw32_walker_bench.sv
module pw32_walker_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] vaddr = '0;
   logic [31:0] root_base = '0;
   logic        large_en = 1'b0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        done, fault, page_large, user_ok, write_ok;
   logic [1:0]  fault_kind;
   logic [39:0] paddr;
   logic [31:0] leaf_entry, leaf_addr;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   logic [31:0] mem [logic [31:0]];
   logic [31:0] lg_addr [8];
   logic        lg_we   [8];
   logic [31:0] lg_wd   [8];
   int          n_acc = 0;

   always #2 clk = ~clk;

   pw32_walker u_pw32_walker (
      .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr),
      .root_base(root_base), .large_en(large_en),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .done(done), .fault(fault), .fault_kind(fault_kind), .paddr(paddr),
      .page_large(page_large), .user_ok(user_ok), .write_ok(write_ok),
      .leaf_entry(leaf_entry), .leaf_addr(leaf_addr)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic responder();
      forever begin
         @(negedge clk);
         if (mem_req && !mem_ack && rst_n) begin
            if (n_acc < 8) begin
               lg_addr[n_acc] = mem_addr;
               lg_we[n_acc]   = mem_we;
               lg_wd[n_acc]   = mem_wdata;
            end
            n_acc++;
            if (mem_we) mem[mem_addr] = mem_wdata;
            mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
            mem_ack = 1'b1;
         end else begin
            mem_ack = 1'b0;
         end
      end
   endtask

   task automatic clear_mem();
      mem.delete();
      n_acc = 0;
   endtask

   task automatic wait_done(output bit ok);
      ok = 0;
      for (int i = 0; i < 200; i++) begin
         if (done) begin ok = 1; break; end
         @(negedge clk);
      end
   endtask

   task automatic run_walk(input logic [31:0] va, input logic [31:0] base,
                           input bit big, output bit ok);
      @(negedge clk);
      vaddr = va; root_base = base; large_en = big; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(ok);
   endtask

   task automatic t_reset();
      chk("R12 mem_req after reset", mem_req, 0);
      chk("R12 done after reset", done, 0);
      chk("R12 fault after reset", fault, 0);
   endtask

   task automatic t_small_wb();
      bit ok;
      clear_mem();
      mem[32'h0001_0120] = 32'h0002_0007;
      mem[32'h0002_0D14] = 32'hCAFE_B005;
      run_walk(32'h1234_5678, 32'h0001_0ABC, 1'b1, ok);
      chk("R3 small walk completes", ok, 1);
      chk("R1 dir addr ignores base low bits", lg_addr[0], 32'h0001_0120);
      chk("R7 access count with write-back", n_acc, 3);
      chk("R7 second access is write", lg_we[1], 1);
      chk("R7 write-back address", lg_addr[1], 32'h0001_0120);
      chk("R7 write-back data", lg_wd[1], 32'h0002_0027);
      chk("R2 table addr", lg_addr[2], 32'h0002_0D14);
      chk("R8 small paddr", paddr, 40'h00_CAFE_B678);
      chk("R8 small no fault", fault, 0);
      chk("R8 small page_large", page_large, 0);
      chk("R9 user ANDed", user_ok, 1);
      chk("R9 write ANDed", write_ok, 0);
      chk("R10 leaf entry", leaf_entry, 32'hCAFE_B005);
      chk("R10 leaf addr", leaf_addr, 32'h0002_0D14);
   endtask

   task automatic t_small_no_wb();
      bit ok;
      clear_mem();
      mem[32'h0005_0FFC] = 32'h0003_00A7;
      mem[32'h0003_0FFC] = 32'h0040_1FFF;
      run_walk(32'hFFFF_F123, 32'h0005_0000, 1'b0, ok);
      chk("R4 size bit ignored when disabled", ok, 1);
      chk("R7 no write when accessed set", n_acc, 2);
      chk("R7 both accesses are reads", {lg_we[0], lg_we[1]}, 0);
      chk("R2 table addr top index", lg_addr[1], 32'h0003_0FFC);
      chk("R8 no reserved check in table", fault, 0);
      chk("R4 small page when disabled", page_large, 0);
      chk("R8 paddr", paddr, 40'h00_0040_1123);
      chk("R9 write both set", write_ok, 1);
      chk("R9 user both set", user_ok, 1);
   endtask

   task automatic t_large();
      bit ok;
      clear_mem();
      mem[32'h0007_0004] = 32'hAACB_4085;
      run_walk(32'h0076_5432, 32'h0007_0000, 1'b1, ok);
      chk("R5 large completes", ok, 1);
      chk("R5 single access", n_acc, 1);
      chk("R5 large paddr", paddr, 40'h5A_AAF6_5432);
      chk("R5 page_large", page_large, 1);
      chk("R9 large user from dir", user_ok, 1);
      chk("R9 large write from dir", write_ok, 0);
      chk("R10 large leaf addr", leaf_addr, 32'h0007_0004);
   endtask

   task automatic t_large_rsvd();
      bit ok;
      clear_mem();
      mem[32'h0007_0004] = 32'hAAEB_4085;
      run_walk(32'h0076_5432, 32'h0007_0000, 1'b1, ok);
      chk("R6 reserved completes", ok, 1);
      chk("R6 reserved fault", fault, 1);
      chk("R6 reserved kind", fault_kind, 2);
      chk("R6 single access", n_acc, 1);
   endtask

   task automatic t_np_dir();
      bit ok;
      clear_mem();
      run_walk(32'h8000_0000, 32'h0009_0000, 1'b1, ok);
      chk("R3 dir absent completes", ok, 1);
      chk("R3 dir absent fault", fault, 1);
      chk("R3 dir absent kind", fault_kind, 1);
      chk("R3 dir absent single access", n_acc, 1);
      chk("R10 dir absent leaf addr", leaf_addr, 32'h0009_0800);
   endtask

   task automatic t_np_tbl();
      bit ok;
      clear_mem();
      mem[32'h0009_0000] = 32'h0004_0021;
      mem[32'h0004_0004] = 32'hFFFF_F000;
      run_walk(32'h0000_1000, 32'h0009_0000, 1'b0, ok);
      chk("R3 table absent completes", ok, 1);
      chk("R3 table absent kind", fault_kind, 1);
      chk("R3 table absent accesses", n_acc, 2);
      chk("R10 table absent leaf", leaf_entry, 32'hFFFF_F000);
      chk("R10 table absent leaf addr", leaf_addr, 32'h0004_0004);
   endtask

   task automatic t_busy_start();
      bit ok;
      int seen;
      clear_mem();
      mem[32'h0001_0120] = 32'h0002_0007;
      mem[32'h0002_0D14] = 32'hCAFE_B005;
      @(negedge clk);
      vaddr = 32'h1234_5678; root_base = 32'h0001_0000; large_en = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      vaddr = 32'h0000_0000; root_base = 32'h0F00_0000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(ok);
      chk("R11 first walk completes", ok, 1);
      chk("R11 paddr from first request", paddr, 40'h00_CAFE_B678);
      chk("R11 accesses of first request", n_acc, 3);
      seen = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (done || mem_req) seen++;
      end
      chk("R11 no second walk", seen, 0);
      chk("R11 result held", paddr, 40'h00_CAFE_B678);
   endtask

   initial begin
      for (int i = 0; i < 100000; i++) begin
         @(posedge clk);
         if (finished) break;
      end
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      fork responder(); join_none
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_small_wb();
      t_small_no_wb();
      t_large();
      t_large_rsvd();
      t_np_dir();
      t_np_tbl();
      t_busy_start();
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule